// File: doc/BRIEF.md
# Associative Tag Lookup with Least-Recently-Used Victim Selection

This block is a small fully associative tag store. Each of its 16 slots holds a 32-bit tag, a 4-bit state value and a valid bit. A lookup strobe compares a key against every valid slot at once. One cycle later the block reports either a hit, with the slot number and its state, or a miss. On a miss it reports the slot that has gone unused the longest, so the caller can load the new tag there.

Recency is kept as an ordered list of slot numbers, from oldest to newest. A write to a slot makes that slot the newest, and so does a lookup hit. A miss leaves the order as it is. A clear input empties the store and restores the initial order. The data that the returned slot number points to is held somewhere else and is not part of this block.

Top module: `assoc_tag_cam`

## Requirements
- R1: After reset, and after a clear, every slot is invalid and a lookup of any key misses, even a key equal to the all-zero tag. The recency order runs from slot 0 (oldest) to slot 15 (newest), so the first miss reports victim 0.
- R2: `res_valid_o` is high in exactly the cycle after a cycle in which `lk_en_i` was high and `clear_i` was low, and it is low otherwise.
- R3: On a lookup hit the result shows `res_hit_o`=1, `res_idx_o` equal to the matching slot, and `res_state_o` equal to that slot's stored state.
- R4: On a lookup miss the result shows `res_hit_o`=0, `res_idx_o` equal to the oldest slot in the recency order, and `res_state_o`=0.
- R5: A write (`wr_en_i`=1) stores `wr_tag_i` and `wr_state_i` in slot `wr_idx_i`, marks that slot valid and makes it the newest in the recency order.
- R6: A lookup hit makes the matched slot the newest in the recency order. A miss leaves the order unchanged.
- R7: If several valid slots hold the key, the slot with the lowest number is reported.
- R8: A write and a lookup in the same cycle behave as if the write came first. The lookup sees the new tag, and a miss reports the victim from the order after the write has been applied.
- R9: A clear overrides a write and a lookup in the same cycle. The write is dropped and no result is produced for that lookup.
- R10: Writing a new tag into an occupied slot replaces the old tag, so the old tag then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Invalidate all slots and restore the initial recency order |
| wr_en_i | input | 1 | Write strobe |
| wr_idx_i | input | 4 | Slot to write |
| wr_tag_i | input | 32 | Tag to store |
| wr_state_i | input | 4 | State value to store |
| lk_en_i | input | 1 | Lookup strobe |
| lk_key_i | input | 32 | Key to search for |
| res_valid_o | output | 1 | Lookup result valid (one cycle after the strobe) |
| res_hit_o | output | 1 | 1 = hit, 0 = miss |
| res_idx_o | output | 4 | Matching slot on a hit, victim slot on a miss |
| res_state_o | output | 4 | State of the matching slot on a hit, 0 on a miss |

## Verification
A wrong entry in the recency list shows up only at the next miss, as an unexpected victim number. The bench therefore places misses straight after each hit, each write and each combined write-and-lookup cycle. A stale or lost valid bit shows up one cycle after the next lookup of that tag, as a hit that should be a miss or a miss that should be a hit. The same-cycle cases are checked in that first result, because a write that is ordered wrongly against a lookup changes the result at once.

// File: rtl/assoc_tag_cam_pkg.sv
package assoc_tag_cam_pkg;
   localparam int unsigned CAM_DEF_ENTRIES = 16;
   localparam int unsigned CAM_DEF_TAG_W   = 32;
   localparam int unsigned CAM_DEF_STATE_W = 4;
   localparam int unsigned CAM_DEF_IDX_W   = $clog2(CAM_DEF_ENTRIES);
endpackage

// File: rtl/cam_tag_store.sv
module cam_tag_store #(
   parameter int unsigned ENTRIES = 16,
   parameter int unsigned TAG_W   = 32,
   parameter int unsigned STATE_W = 4,
   parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              clear_i,
   input  logic                              wr_en_i,
   input  logic [IDX_W-1:0]                  wr_idx_i,
   input  logic [TAG_W-1:0]                  wr_tag_i,
   input  logic [STATE_W-1:0]                wr_state_i,
   output logic [ENTRIES-1:0]                eff_valid_o,
   output logic [ENTRIES-1:0][TAG_W-1:0]     eff_tag_o,
   output logic [ENTRIES-1:0][STATE_W-1:0]   eff_state_o,
   output logic [ENTRIES-1:0]                valid_q_o,
   output logic [ENTRIES-1:0][TAG_W-1:0]     tag_q_o
);
   logic [ENTRIES-1:0]              valid_q;
   logic [ENTRIES-1:0][TAG_W-1:0]   tag_q;
   logic [ENTRIES-1:0][STATE_W-1:0] state_q;
   logic                            wr_go;

   assign wr_go = wr_en_i && !clear_i;

   // Post-write view: a lookup in the same cycle sees the write first
   for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
      logic sel;
      assign sel = wr_go && (wr_idx_i == IDX_W'(e));

      assign eff_valid_o[e] = sel ? 1'b1       : valid_q[e];
      assign eff_tag_o[e]   = sel ? wr_tag_i   : tag_q[e];
      assign eff_state_o[e] = sel ? wr_state_i : state_q[e];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q[e] <= 1'b0;
            tag_q[e]   <= '0;
            state_q[e] <= '0;
         end else if (clear_i) begin
            valid_q[e] <= 1'b0;
         end else if (sel) begin
            valid_q[e] <= 1'b1;
            tag_q[e]   <= wr_tag_i;
            state_q[e] <= wr_state_i;
         end
      end
   end

   assign valid_q_o = valid_q;
   assign tag_q_o   = tag_q;

   a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (valid_q == '0));

   a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !clear_i) |=> (valid_q[$past(wr_idx_i)] &&
                                 tag_q[$past(wr_idx_i)] == $past(wr_tag_i)));
endmodule

// File: rtl/cam_match_unit.sv
module cam_match_unit #(
   parameter int unsigned ENTRIES = 16,
   parameter int unsigned TAG_W   = 32,
   parameter int unsigned STATE_W = 4,
   parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [TAG_W-1:0]                  key_i,
   input  logic [ENTRIES-1:0]                valid_i,
   input  logic [ENTRIES-1:0][TAG_W-1:0]     tag_i,
   input  logic [ENTRIES-1:0][STATE_W-1:0]   state_i,
   output logic                              hit_o,
   output logic [IDX_W-1:0]                  hit_idx_o,
   output logic [STATE_W-1:0]                hit_state_o
);
   logic [ENTRIES-1:0] match_vec;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign match_vec[e] = valid_i[e] && (tag_i[e] == key_i);
   end

   // Lowest slot number wins: scan from the top so the last assignment is the lowest
   always_comb begin
      hit_idx_o = '0;
      for (int e = ENTRIES - 1; e >= 0; e--) begin
         if (match_vec[e]) hit_idx_o = IDX_W'(e);
      end
   end

   assign hit_o       = |match_vec;
   assign hit_state_o = state_i[hit_idx_o];

   logic [ENTRIES-1:0] below_mask;
   assign below_mask = ({{(ENTRIES-1){1'b0}}, 1'b1} << hit_idx_o) - 1'b1;

   a_r7_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> ((match_vec & below_mask) == '0) && match_vec[hit_idx_o]);
endmodule

// File: rtl/cam_lru_order.sv
module cam_lru_order #(
   parameter int unsigned ENTRIES = 16,
   parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             first_en_i,
   input  logic [IDX_W-1:0] first_idx_i,
   input  logic             second_en_i,
   input  logic [IDX_W-1:0] second_idx_i,
   output logic [IDX_W-1:0] victim_o,
   output logic [IDX_W-1:0] oldest_q_o,
   output logic [IDX_W-1:0] newest_q_o
);
   typedef logic [ENTRIES-1:0][IDX_W-1:0] order_t;

   order_t order_q, order_mid, order_nxt;

   function automatic order_t promote(input order_t o, input logic [IDX_W-1:0] x);
      order_t r;
      logic   seen;
      seen = 1'b0;
      for (int i = 0; i < ENTRIES - 1; i++) begin
         if (o[i] == x) seen = 1'b1;
         r[i] = seen ? o[i+1] : o[i];
      end
      r[ENTRIES-1] = x;
      return r;
   endfunction

   always_comb begin
      order_mid = first_en_i  ? promote(order_q, first_idx_i)    : order_q;
      order_nxt = second_en_i ? promote(order_mid, second_idx_i) : order_mid;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) order_q[i] <= IDX_W'(i);
      end else if (clear_i) begin
         for (int i = 0; i < ENTRIES; i++) order_q[i] <= IDX_W'(i);
      end else begin
         order_q <= order_nxt;
      end
   end

   assign victim_o   = order_mid[0];
   assign oldest_q_o = order_q[0];
   assign newest_q_o = order_q[ENTRIES-1];

   logic [ENTRIES-1:0] present;
   always_comb begin
      present = '0;
      for (int i = 0; i < ENTRIES; i++) present[order_q[i]] = 1'b1;
   end

   a_r6_order_is_permutation: assert property (@(posedge clk) disable iff (!rst_n)
      present == {ENTRIES{1'b1}});
endmodule

// File: rtl/assoc_tag_cam.sv
module assoc_tag_cam
   import assoc_tag_cam_pkg::*;
#(
   parameter int unsigned ENTRIES = CAM_DEF_ENTRIES,
   parameter int unsigned TAG_W   = CAM_DEF_TAG_W,
   parameter int unsigned STATE_W = CAM_DEF_STATE_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clear_i,
   input  logic                        wr_en_i,
   input  logic [$clog2(ENTRIES)-1:0]  wr_idx_i,
   input  logic [TAG_W-1:0]            wr_tag_i,
   input  logic [STATE_W-1:0]          wr_state_i,
   input  logic                        lk_en_i,
   input  logic [TAG_W-1:0]            lk_key_i,
   output logic                        res_valid_o,
   output logic                        res_hit_o,
   output logic [$clog2(ENTRIES)-1:0]  res_idx_o,
   output logic [STATE_W-1:0]          res_state_o
);
   localparam int unsigned IDX_W = $clog2(ENTRIES);

   if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_bad_entries
      $error("ENTRIES must be a power of two, at least 2");
   end
   if (TAG_W < 1 || STATE_W < 1) begin : g_bad_width
      $error("TAG_W and STATE_W must be positive");
   end

   logic [ENTRIES-1:0]              eff_valid, valid_q;
   logic [ENTRIES-1:0][TAG_W-1:0]   eff_tag, tag_q;
   logic [ENTRIES-1:0][STATE_W-1:0] eff_state;
   logic                            hit;
   logic [IDX_W-1:0]                hit_idx, victim, oldest_q, newest_q;
   logic [STATE_W-1:0]              hit_state;
   logic                            lk_go, wr_go;

   assign lk_go = lk_en_i && !clear_i;
   assign wr_go = wr_en_i && !clear_i;

   cam_tag_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .STATE_W(STATE_W), .IDX_W(IDX_W)) store_i (
      .clk(clk), .rst_n(rst_n), .clear_i(clear_i),
      .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_tag_i(wr_tag_i), .wr_state_i(wr_state_i),
      .eff_valid_o(eff_valid), .eff_tag_o(eff_tag), .eff_state_o(eff_state),
      .valid_q_o(valid_q), .tag_q_o(tag_q)
   );

   cam_match_unit #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .STATE_W(STATE_W), .IDX_W(IDX_W)) match_i (
      .clk(clk), .rst_n(rst_n), .key_i(lk_key_i),
      .valid_i(eff_valid), .tag_i(eff_tag), .state_i(eff_state),
      .hit_o(hit), .hit_idx_o(hit_idx), .hit_state_o(hit_state)
   );

   cam_lru_order #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) order_i (
      .clk(clk), .rst_n(rst_n), .clear_i(clear_i),
      .first_en_i(wr_go), .first_idx_i(wr_idx_i),
      .second_en_i(lk_go && hit), .second_idx_i(hit_idx),
      .victim_o(victim), .oldest_q_o(oldest_q), .newest_q_o(newest_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid_o <= 1'b0;
         res_hit_o   <= 1'b0;
         res_idx_o   <= '0;
         res_state_o <= '0;
      end else begin
         res_valid_o <= lk_go;
         if (lk_go) begin
            res_hit_o   <= hit;
            res_idx_o   <= hit ? hit_idx : victim;
            res_state_o <= hit ? hit_state : '0;
         end
      end
   end

   a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_en_i && !clear_i) |=> res_valid_o);

   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !(lk_en_i && !clear_i) |=> !res_valid_o);

   a_r3_hit_slot_holds_key: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && res_hit_o) |-> (valid_q[res_idx_o] && tag_q[res_idx_o] == $past(lk_key_i)));

   a_r4_miss_is_oldest: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && !res_hit_o) |-> (res_idx_o == oldest_q && res_state_o == '0));

   a_r6_hit_is_newest: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && res_hit_o) |-> (newest_q == res_idx_o));

   a_r5_write_is_newest: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !clear_i && !(lk_en_i && hit)) |=> (newest_q == $past(wr_idx_i)));
endmodule

// File: tb/assoc_tag_cam_tb_top.sv
module assoc_tag_cam_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 21;

   typedef struct packed {
      logic        clr;
      logic        we;
      logic [3:0]  widx;
      logic [31:0] wtag;
      logic [3:0]  wst;
      logic        le;
      logic [31:0] key;
      logic        ev;
      logic        eh;
      logic [3:0]  eidx;
      logic [3:0]  est;
      logic [7:0]  req;
   } vec_t;

   // clr we widx wtag st le key | ev eh eidx est | req
   localparam vec_t VECS [NVEC] = '{
      '{1'b0,1'b0,4'd0,32'h0,4'd0,1'b1,32'hA5A5_0001, 1'b1,1'b0,4'd0,4'd0, 8'd1},  // R1 first miss victim 0
      '{1'b0,1'b1,4'd0,32'h1111_0000,4'd3,1'b0,32'h0, 1'b0,1'b0,4'd0,4'd0, 8'd5},  // R5 write slot 0
      '{1'b0,1'b0,4'd0,32'h0,4'd0,1'b1,32'h1111_0000, 1'b1,1'b1,4'd0,4'd3, 8'd3},  // R3 hit slot 0
      '{1'b0,1'b0,4'd0,32'h0,4'd0,1'b1,32'hDEAD_BEEF, 1'b1,1'b0,4'd1,4'd0, 8'd4},  // R4 miss victim 1
      '{1'b0,1'b0,4'd0,32'h0,4'd0,1'b1,32'hDEAD_BEEF, 1'b1,1'b0,4'd1,4'd0, 8'd6},  // R6 miss keeps order
      '{1'b0,1'b1,4'd5,32'h5555_5555,4'd9,1'b0,32'h0, 1'b0,1'b0,4'd0,4'd0, 8'd5},
      '{1'b0,1'b1,4'd1,32'h0000_2222,4'd1,1'b0,32'h0, 1'b0,1'b0,4'd0,4'd0, 8'd5},
      '{1'b0,1'b0,4'd0,32'h0,4'd0,1'b1,32'h1111_0000, 1'b1,1'b1,4'd0,4'd3, 8'd6},  // R6 hit promotes 0
      '{1'b0,1'b0,4'd0,32'h0,4'd0,1'b1,32'h0000_0000, 1'b1,1'b0,4'd2,4'd0, 8'd1},  // R1 invalid zero tag misses
      '{1'b0,1'b1,4'd7,32'h5555_5555,4'd12,1'b0,32'h0, 1'b0,1'b0,4'd0,4'd0, 8'd5},
      '{1'b0,1'b0,4'd0,32'h0,4'd0,1'b1,32'h5555_5555, 1'b1,1'b1,4'd5,4'd9, 8'd7},  // R7 lowest of 5,7
      '{1'b0,1'b1,4'd2,32'h0000_7777,4'd6,1'b1,32'h0000_7777, 1'b1,1'b1,4'd2,4'd6, 8'd8},  // R8 write seen
      '{1'b0,1'b0,4'd0,32'h0,4'd0,1'b1,32'hFFFF_FFFF, 1'b1,1'b0,4'd3,4'd0, 8'd6},  // R6 order after hits
      '{1'b0,1'b1,4'd3,32'h0000_3333,4'd15,1'b1,32'h0000_9999, 1'b1,1'b0,4'd4,4'd0, 8'd8},  // R8 victim after write
      '{1'b0,1'b1,4'd0,32'h0000_ABCD,4'd2,1'b0,32'h0, 1'b0,1'b0,4'd0,4'd0, 8'd10},
      '{1'b0,1'b0,4'd0,32'h0,4'd0,1'b1,32'h1111_0000, 1'b1,1'b0,4'd4,4'd0, 8'd10}, // R10 old tag gone
      '{1'b0,1'b0,4'd0,32'h0,4'd0,1'b1,32'h0000_ABCD, 1'b1,1'b1,4'd0,4'd2, 8'd10}, // R10 new tag hits
      '{1'b1,1'b1,4'd4,32'h0000_4444,4'd5,1'b1,32'h0000_4444, 1'b0,1'b0,4'd0,4'd0, 8'd9},  // R9 clear wins
      '{1'b0,1'b0,4'd0,32'h0,4'd0,1'b1,32'h0000_4444, 1'b1,1'b0,4'd0,4'd0, 8'd9},  // R9 write dropped
      '{1'b0,1'b0,4'd0,32'h0,4'd0,1'b1,32'h0000_ABCD, 1'b1,1'b0,4'd0,4'd0, 8'd9},  // R9 slots empty
      '{1'b0,1'b0,4'd0,32'h0,4'd0,1'b0,32'h0000_ABCD, 1'b0,1'b0,4'd0,4'd0, 8'd2}   // R2 no strobe no result
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clear_i = 1'b0, wr_en_i = 1'b0, lk_en_i = 1'b0;
   logic [3:0]  wr_idx_i = '0, wr_state_i = '0;
   logic [31:0] wr_tag_i = '0, lk_key_i = '0;
   logic        res_valid_o, res_hit_o;
   logic [3:0]  res_idx_o, res_state_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assoc_tag_cam dut_i (
      .clk(clk), .rst_n(rst_n), .clear_i(clear_i),
      .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_tag_i(wr_tag_i), .wr_state_i(wr_state_i),
      .lk_en_i(lk_en_i), .lk_key_i(lk_key_i),
      .res_valid_o(res_valid_o), .res_hit_o(res_hit_o),
      .res_idx_o(res_idx_o), .res_state_o(res_state_o)
   );

   task automatic drive(input vec_t v);
      clear_i = v.clr; wr_en_i = v.we; wr_idx_i = v.widx; wr_tag_i = v.wtag;
      wr_state_i = v.wst; lk_en_i = v.le; lk_key_i = v.key;
   endtask

   task automatic idle();
      clear_i = 0; wr_en_i = 0; lk_en_i = 0;
   endtask

   task automatic expect_res(input logic ev, input logic eh, input logic [3:0] eidx,
                             input logic [3:0] est, input int req, input string what);
      logic ok;
      checks++;
      ok = (res_valid_o == ev);
      if (ev) ok = ok && (res_hit_o == eh) && (res_idx_o == eidx) && (res_state_o == est);
      if (!ok) begin
         fails++;
         $display("FAIL R%0d %s: got v=%0b h=%0b idx=%0d st=%0d, expected v=%0b h=%0b idx=%0d st=%0d",
                  req, what, res_valid_o, res_hit_o, res_idx_o, res_state_o, ev, eh, eidx, est);
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1 reset state at the ports
      expect_res(1'b0, 1'b0, 4'd0, 4'd0, 1, "reset outputs");
      checks++;
      if (res_hit_o !== 1'b0 || res_idx_o !== 4'd0 || res_state_o !== 4'd0) begin
         fails++;
         $display("FAIL R1 reset fields: got h=%0b idx=%0d st=%0d, expected 0 0 0",
                  res_hit_o, res_idx_o, res_state_o);
      end
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NVEC; i++) begin
         drive(VECS[i]);
         @(negedge clk);
         expect_res(VECS[i].ev, VECS[i].eh, VECS[i].eidx, VECS[i].est, int'(VECS[i].req),
                    $sformatf("vector %0d", i));
      end
      idle();
      @(negedge clk);

      // Fill all slots newest-last in order 15 down to 0; oldest is then 15 (R4, R5)
      for (int s = 15; s >= 0; s--) begin
         wr_en_i = 1; wr_idx_i = 4'(s); wr_tag_i = 32'h1000 + 32'(s); wr_state_i = 4'(s);
         @(negedge clk);
      end
      idle();
      lk_en_i = 1; lk_key_i = 32'h0BAD_0BAD;
      @(negedge clk);
      expect_res(1'b1, 1'b0, 4'd15, 4'd0, 4, "full store victim");
      lk_key_i = 32'h1008;
      @(negedge clk);
      expect_res(1'b1, 1'b1, 4'd8, 4'd8, 3, "full store hit 8");
      lk_key_i = 32'h0BAD_0BAD;
      @(negedge clk);
      expect_res(1'b1, 1'b0, 4'd15, 4'd0, 6, "hit on 8 leaves oldest");
      idle();

      // Reset in the middle of use (R1)
      rst_n = 1'b0;
      @(negedge clk);
      expect_res(1'b0, 1'b0, 4'd0, 4'd0, 1, "mid reset outputs");
      rst_n = 1'b1;
      lk_en_i = 1; lk_key_i = 32'h1008;
      @(negedge clk);
      expect_res(1'b1, 1'b0, 4'd0, 4'd0, 1, "after reset old tag misses");
      idle();
      @(negedge clk);
      expect_res(1'b0, 1'b0, 4'd0, 4'd0, 2, "valid drops after strobe");

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule